// File: doc/BRIEF.md
# Door Closing Sequence Controller

This block sequences the closing of one passenger door group. A driver works a three-position selector. The positions are open, signal and close. The block tracks where the selector stands and runs a closing-warning ringer off a countdown timer that represents three seconds. It drives an indicator light that shows a selected door group. It also produces the close command for the door actuator and the open-authorization output.

The selector position arrives as three request lines. The block resolves them by priority into a registered position. A closing move from the open position always stops at signal first, so the warning is never skipped. Entering signal starts the ringer and loads the timer. The ringer keeps sounding for at least the full timer period. After that it falls silent only once the selector rests at close. The close command is issued only when the selector is at close and the warning has run its full time. The close command stays active until the closed-door sensor reports. Returning the selector to open re-enables opening. Open authorization is then passed through from an upstream grant, provided no warning is sounding. Speed-based inhibition and input filtering are done elsewhere. This block only consumes the inhibit and grant results.

Top module: `door_close_seq`

## Requirements
- R1: After reset, and for as long as reset is held, sel_pos is 0 (open), and warn_timeout, ringing, light_on, close_cmd and open_auth are all 0.
- R2: At each clock edge the requested position is close if req_close is high, otherwise signal if req_signal is high, otherwise open if req_open is high. With no request the selector holds its position.
- R3: sel_pos encodes open as 0, signal as 1 and close as 2. From open, a close request moves the selector to signal, never straight to close. Every other move lands on the requested position in one edge.
- R4: When the selector enters signal, the timer restarts. warn_timeout is high for exactly one cycle: the TICKS-th cycle, counting the first cycle in signal as cycle 1. Re-entering signal restarts the count.
- R5: ringing rises at the same edge at which the selector enters signal. The selector is never at signal while the ringer is silent.
- R6: Once started, ringing stays high for at least TICKS cycles. After that it clears only at an edge where the selector is at close. Returning to open does not silence it.
- R7: While at open, not ringing and not inhibited, light_on is set one edge after group_sel is high. It then stays set without further selection.
- R8: light_on clears at the edge where open_inhibit is high, where the selector leaves open, or where ringing starts. light_on is never high together with ringing, signal or close.
- R9: close_cmd rises one edge after the selector is at close with the warning time complete. It falls one edge after door_closed is sampled high, or after the selector is seen back at open.
- R10: open_auth is a registered output. It is high only when the door logic permits opening, the selector is at open, open_grant is high and the ringer is silent. After a close cycle, opening is permitted again one edge after the selector is seen at open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_open | input | 1 | Selector requests the open position |
| req_signal | input | 1 | Selector requests the signal position |
| req_close | input | 1 | Selector requests the close position |
| door_closed | input | 1 | Sensor: door group fully closed |
| group_sel | input | 1 | Driver has selected this door group |
| open_inhibit | input | 1 | Opening is inhibited (from the speed logic) |
| open_grant | input | 1 | Upstream grant for opening |
| sel_pos | output | 2 | Registered selector position (0 open, 1 signal, 2 close) |
| warn_timeout | output | 1 | One-cycle pulse at the end of the warning time |
| ringing | output | 1 | Closing-warning ringer active |
| light_on | output | 1 | Door-group indicator light |
| close_cmd | output | 1 | Close command to the door actuator |
| open_auth | output | 1 | Open authorization for the door group |

## Verification
The bench raises all three requests in one cycle from open. A design with the wrong priority or a missing signal stop would jump straight to close, or stay put, and the ringer would not start. It counts ringer cycles while close is held throughout. A release that ignored the minimum time would drop the ringer early. A design with a late timeout would hold back the close command by a visible number of cycles. It aborts from signal back to open before the timeout. A ringer that cleared on any release would fall silent there and wrongly let open authorization through. It also checks the latched light against inhibit and against ringing, and a light that only followed group_sel would go dark one cycle after selection. Long random runs are compared against a cycle-level reference model to catch re-entry and sensor races.

// File: rtl/door_seq_pkg.sv
package door_seq_pkg;

    typedef enum logic [1:0] {
        POS_OPEN   = 2'd0,
        POS_SIGNAL = 2'd1,
        POS_CLOSE  = 2'd2
    } pos_e;

    typedef enum logic [1:0] {
        DR_PERMIT  = 2'd0,
        DR_CLOSING = 2'd1,
        DR_SHUT    = 2'd2
    } door_e;

    typedef struct packed {
        logic ring;
        logic light;
    } annun_t;

    typedef struct packed {
        door_e state;
        logic  auth;
    } door_t;

endpackage

// File: rtl/dcs_selector.sv
module dcs_selector
    import door_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_open,
    input  logic req_signal,
    input  logic req_close,
    output pos_e pos_q,
    output pos_e pos_d
);
    pos_e target;

    // Priority resolve, then keep a closing move from skipping the warning stop
    always_comb begin
        target = pos_q;
        if (req_close)
            target = POS_CLOSE;
        else if (req_signal)
            target = POS_SIGNAL;
        else if (req_open)
            target = POS_OPEN;

        pos_d = target;
        if (pos_q == POS_OPEN && target == POS_CLOSE)
            pos_d = POS_SIGNAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= POS_OPEN;
        else
            pos_q <= pos_d;
    end
endmodule

// File: rtl/dcs_warn_timer.sv
module dcs_warn_timer #(
    parameter int TICKS = 375_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic timeout,
    output logic done_q
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run  = 1'b1;
            tmr_d.done = 1'b0;
            tmr_d.cnt  = LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run  = 1'b0;
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr_q <= '0;
        else
            tmr_q <= tmr_d;
    end

    assign timeout = tmr_q.run && (tmr_q.cnt == '0);
    assign done_q  = tmr_q.done;
endmodule

// File: rtl/dcs_annunciator.sv
module dcs_annunciator
    import door_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pos_e pos_d,
    input  logic timeout,
    input  logic done_q,
    input  logic group_sel,
    input  logic open_inhibit,
    output logic ring_q,
    output logic ring_d,
    output logic light_q
);
    annun_t an_d, an_q;
    logic   release_ok;

    always_comb begin
        release_ok  = (done_q | timeout) && (pos_d == POS_CLOSE);
        an_d.ring   = (pos_d == POS_SIGNAL) | (an_q.ring & ~release_ok);
        an_d.light  = (an_q.light | group_sel) & ~open_inhibit
                    & (pos_d == POS_OPEN) & ~an_d.ring;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            an_q <= '0;
        else
            an_q <= an_d;
    end

    assign ring_q  = an_q.ring;
    assign ring_d  = an_d.ring;
    assign light_q = an_q.light;
endmodule

// File: rtl/dcs_door_logic.sv
module dcs_door_logic
    import door_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pos_e pos_q,
    input  pos_e pos_d,
    input  logic done_q,
    input  logic door_closed,
    input  logic open_grant,
    input  logic ring_d,
    output logic close_cmd,
    output logic open_auth
);
    door_t dr_d, dr_q;

    always_comb begin
        dr_d = dr_q;
        unique case (dr_q.state)
            DR_PERMIT:
                if (pos_q == POS_CLOSE && done_q)
                    dr_d.state = DR_CLOSING;
            DR_CLOSING:
                if (pos_q == POS_OPEN)
                    dr_d.state = DR_PERMIT;
                else if (door_closed)
                    dr_d.state = DR_SHUT;
            DR_SHUT:
                if (pos_q == POS_OPEN)
                    dr_d.state = DR_PERMIT;
            default:
                dr_d.state = DR_PERMIT;
        endcase
        dr_d.auth = (dr_d.state == DR_PERMIT) && (pos_d == POS_OPEN)
                  && open_grant && !ring_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dr_q <= '{state: DR_PERMIT, auth: 1'b0};
        else
            dr_q <= dr_d;
    end

    assign close_cmd = (dr_q.state == DR_CLOSING);
    assign open_auth = dr_q.auth;
endmodule

// File: rtl/door_close_seq.sv
module door_close_seq
    import door_seq_pkg::*;
#(
    parameter int TICKS = 375_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_open,
    input  logic       req_signal,
    input  logic       req_close,
    input  logic       door_closed,
    input  logic       group_sel,
    input  logic       open_inhibit,
    input  logic       open_grant,
    output logic [1:0] sel_pos,
    output logic       warn_timeout,
    output logic       ringing,
    output logic       light_on,
    output logic       close_cmd,
    output logic       open_auth
);
    pos_e pos_q, pos_d;
    logic enter_signal;
    logic done_q;
    logic ring_d;

    dcs_selector u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_open  (req_open),
        .req_signal(req_signal),
        .req_close (req_close),
        .pos_q     (pos_q),
        .pos_d     (pos_d)
    );

    assign enter_signal = (pos_d == POS_SIGNAL) && (pos_q != POS_SIGNAL);

    dcs_warn_timer #(.TICKS(TICKS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (enter_signal),
        .timeout(warn_timeout),
        .done_q (done_q)
    );

    dcs_annunciator u_ann (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_d       (pos_d),
        .timeout     (warn_timeout),
        .done_q      (done_q),
        .group_sel   (group_sel),
        .open_inhibit(open_inhibit),
        .ring_q      (ringing),
        .ring_d      (ring_d),
        .light_q     (light_on)
    );

    dcs_door_logic u_door (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_q      (pos_q),
        .pos_d      (pos_d),
        .done_q     (done_q),
        .door_closed(door_closed),
        .open_grant (open_grant),
        .ring_d     (ring_d),
        .close_cmd  (close_cmd),
        .open_auth  (open_auth)
    );

    assign sel_pos = pos_q;
endmodule

// File: rtl/door_close_seq_chk.sv
module door_close_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel_pos,
    input logic       warn_timeout,
    input logic       ringing,
    input logic       light_on,
    input logic       close_cmd,
    input logic       open_auth
);
    assert_no_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pos == 2'd0) |=> (sel_pos != 2'd2));

    assert_timeout_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        warn_timeout |=> !warn_timeout);

    assert_signal_rings_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pos == 2'd1) |-> ringing);

    assert_ring_clears_at_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ringing) |-> (sel_pos == 2'd2));

    assert_light_not_ringing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        light_on |-> !ringing);

    assert_light_only_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        light_on |-> (sel_pos == 2'd0));

    assert_close_from_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(close_cmd) |-> ($past(sel_pos) == 2'd2));

    assert_auth_open_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        open_auth |-> ((sel_pos == 2'd0) && !ringing));
endmodule

bind door_close_seq door_close_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_pos     (sel_pos),
    .warn_timeout(warn_timeout),
    .ringing     (ringing),
    .light_on    (light_on),
    .close_cmd   (close_cmd),
    .open_auth   (open_auth)
);

// File: tb/door_close_seq_tb.sv
`timescale 1ns/1ps
module door_close_seq_tb;
    localparam int TK = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_open = 0, req_signal = 0, req_close = 0;
    logic door_closed = 0, group_sel = 0, open_inhibit = 0, open_grant = 0;
    logic [1:0] sel_pos;
    logic warn_timeout, ringing, light_on, close_cmd, open_auth;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    door_close_seq #(.TICKS(TK)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_open(req_open), .req_signal(req_signal), .req_close(req_close),
        .door_closed(door_closed), .group_sel(group_sel),
        .open_inhibit(open_inhibit), .open_grant(open_grant),
        .sel_pos(sel_pos), .warn_timeout(warn_timeout), .ringing(ringing),
        .light_on(light_on), .close_cmd(close_cmd), .open_auth(open_auth)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: position 0/1/2, a remaining-ticks count, flags
    int  m_pos = 0, m_left = 0, m_door = 0;
    bit  m_active = 0, m_served = 0, m_ring = 0, m_light = 0, m_auth = 0;

    function automatic bit m_tout();
        return m_active && (m_left == 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_left = 0; m_door = 0;
            m_active = 0; m_served = 0; m_ring = 0; m_light = 0; m_auth = 0;
        end else begin
            int want, npos, ndoor;
            bit tout, nring, nlight;
            want = req_close ? 2 : req_signal ? 1 : req_open ? 0 : m_pos;
            npos = (m_pos == 0 && want == 2) ? 1 : want;
            tout = m_tout();
            nring = (npos == 1) || (m_ring && !((m_served || tout) && npos == 2));
            nlight = (m_light || group_sel) && !open_inhibit && npos == 0 && !nring;
            ndoor = m_door;
            if (m_door == 0 && m_pos == 2 && m_served) ndoor = 1;
            else if (m_door != 0 && m_pos == 0) ndoor = 0;
            else if (m_door == 1 && door_closed) ndoor = 2;
            m_auth = (ndoor == 0) && npos == 0 && open_grant && !nring;
            if (npos == 1 && m_pos != 1) begin
                m_active = 1; m_served = 0; m_left = TK - 1;
            end else if (m_active) begin
                if (m_left == 0) begin m_active = 0; m_served = 1; end
                else m_left--;
            end
            m_pos = npos; m_ring = nring; m_light = nlight; m_door = ndoor;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2/R3 sel_pos", int'(sel_pos), m_pos);
            chk("R4 warn_timeout", int'(warn_timeout), int'(m_tout()));
            chk("R5/R6 ringing", int'(ringing), int'(m_ring));
            chk("R7/R8 light_on", int'(light_on), int'(m_light));
            chk("R9 close_cmd", int'(close_cmd), int'(m_door == 1));
            chk("R10 open_auth", int'(open_auth), int'(m_auth));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int ring_cnt, to_cnt;
        step(3);
        chk("R1 reset sel_pos", int'(sel_pos), 0);
        chk("R1 reset ringing", int'(ringing), 0);
        chk("R1 reset outputs", int'({warn_timeout, light_on, close_cmd, open_auth}), 0);
        rst_n = 1;
        step(1);
        chk("R1 after reset", int'({sel_pos, warn_timeout, ringing, light_on, close_cmd, open_auth}), 0);

        // Light latch and inhibit
        group_sel = 1; step(1); group_sel = 0;
        chk("R7 light set", int'(light_on), 1);
        step(2);
        chk("R7 light held", int'(light_on), 1);
        open_inhibit = 1; step(1); open_inhibit = 0;
        chk("R8 light inhibited", int'(light_on), 0);
        step(1);
        chk("R7 no relatch", int'(light_on), 0);
        group_sel = 1; step(1); group_sel = 0;

        // All requests at once from open
        req_open = 1; req_signal = 1; req_close = 1;
        step(1);
        chk("R3 close from open stops at signal", int'(sel_pos), 1);
        chk("R5 ringing on entry", int'(ringing), 1);
        chk("R8 light off when ringing", int'(light_on), 0);
        req_open = 0; req_signal = 0;
        ring_cnt = int'(ringing); to_cnt = int'(warn_timeout);
        for (int k = 1; k <= TK + 4; k++) begin
            step(1);
            if (k == 1) chk("R2 close wins", int'(sel_pos), 2);
            ring_cnt += int'(ringing);
            to_cnt += int'(warn_timeout);
        end
        chk("R6 ring length", ring_cnt, TK);
        chk("R4 single timeout", to_cnt, 1);
        chk("R9 close issued", int'(close_cmd), 1);
        door_closed = 1; step(1); door_closed = 0;
        chk("R9 close drops on sensor", int'(close_cmd), 0);

        // Back to open, grant opening
        req_close = 0; req_open = 1; open_grant = 1;
        step(1);
        chk("R2 back to open", int'(sel_pos), 0);
        step(1);
        chk("R10 auth after return", int'(open_auth), 1);

        // Signal beats open, then abort before timeout
        req_signal = 1;
        step(1);
        chk("R2 signal over open", int'(sel_pos), 1);
        chk("R10 no auth while ringing", int'(open_auth), 0);
        req_signal = 0;
        step(TK + 2);
        chk("R6 ringing persists at open", int'(ringing), 1);
        chk("R10 auth blocked by ringer", int'(open_auth), 0);
        req_open = 0;
        step(3);
        chk("R2 hold with no request", int'(sel_pos), 0);

        // Random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            req_open     = ($urandom % 8) == 0;
            req_signal   = ($urandom % 10) == 0;
            req_close    = ($urandom % 8) == 0;
            door_closed  = ($urandom % 4) == 0;
            group_sel    = ($urandom % 6) == 0;
            open_inhibit = ($urandom % 10) == 0;
            open_grant   = ($urandom % 2) == 0;
            step(1);
        end
        summary();
    end
endmodule